// File: doc/BRIEF.md
# Multimode Gate and Delay Generator

This block is a single timing channel. A trigger pulse starts it, and it then drives a gate output whose position and length come from two 32-bit count values, each counted in clock cycles. The count values are 8 ns steps at a 125 MHz clock. A 4-bit mode word selects the behaviour. The low three bits choose among these codes:

- off
- one-shot delayed gate that cannot be retriggered
- latch that opens on a trigger and closes on a stop
- free-running pulser
- gate that a new trigger extends
- divide-by-n prescaler
- complementary prescaler

The top bit of the mode word lets a veto level block the channel's triggers.

A surrounding chip selects the trigger, stop, veto and master-reset signals through its own multiplexers and feeds them here as single-cycle pulses or levels. A software strobe can trigger the channel, and another software strobe can reset it. Besides the gate, the block emits a one-cycle marker just after every falling edge of the gate, so that downstream logic can react to the end of a window.

Top module: `multimode_gate_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `gate_o` and `tail_o` are low.
- R2: Mode code 0 or 7 in `mode_i[2:0]` makes the channel ignore every trigger and forces it idle, so `gate_o` stays low.
- R3: In mode code 1, a trigger sampled at clock edge k makes `gate_o` rise after edge k+D and stay high for W cycles. Here D is `delay_i` and W is `width_i`, and a value of 0 counts as 1.
- R4: In mode code 1, triggers that arrive while the delay or the gate is running have no effect.
- R5: In mode code 4, each trigger sampled while the gate is high lengthens the remaining gate by W cycles. Triggers during the delay are ignored.
- R6: In mode code 2, `gate_o` goes high after the edge that samples a trigger, ignoring `delay_i`. It stays high until a stop.
- R7: A stop returns the channel to idle in every mode and drops the gate after the sampling edge. The stop is any of three: `stop_i`, `sw_reset_i`, or `mreset_i` with `mreset_en_i` high. `mreset_i` with `mreset_en_i` low does nothing.
- R8: In mode code 3, the gate runs without triggers. It repeats with a rising-edge period of D+W cycles and a high time of W cycles.
- R9: In mode code 5 with N = W, the gate goes high for one cycle after the edge that samples every N-th trigger. The count starts at the first trigger after the mode is entered.
- R10: In mode code 6, the one-cycle gate follows each trigger that mode 5 would not answer, so that N-1 of every N triggers produce a gate.
- R11: When `mode_i[3]` is 1 and `veto_i` is high, triggers are ignored. When `mode_i[3]` is 0, the veto has no effect.
- R12: `sw_trig_i` acts exactly like `trig_i`, including retriggering.
- R13: `tail_o` is high for exactly one cycle, after the edge on which `gate_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Bits 2:0 behaviour code, bit 3 veto susceptibility |
| delay_i | input | 32 | Delay in cycles (0 means 1) |
| width_i | input | 32 | Gate length in cycles, or prescale factor N (0 means 1) |
| trig_i | input | 1 | Selected trigger pulse |
| stop_i | input | 1 | Selected stop pulse |
| veto_i | input | 1 | Veto level |
| mreset_i | input | 1 | Master reset pulse |
| mreset_en_i | input | 1 | Lets the master reset stop this channel |
| sw_reset_i | input | 1 | Software reset strobe |
| sw_trig_i | input | 1 | Software trigger strobe |
| gate_o | output | 1 | Gate output |
| tail_o | output | 1 | One-cycle pulse after the gate falls |

## Verification
A vector table fires single triggers through the timing modes, with delay and width values that include zero and one. This separates an off-by-one error in the delay from one in the gate length, and separates the off codes from the live ones. Second triggers placed inside a running gate tell apart the one-shot mode, which must ignore them, from the extending mode, which must add a full length. Each software strobe is checked against its hardware counterpart. A row of nine equally spaced triggers is applied in both prescaler modes, and the position of every answered trigger is checked. The latch is closed once from each stop source, and also offered a master reset with the enable bit low, so that a stop routed to the wrong source shows up.

// File: rtl/gdg_pkg.sv
package gdg_pkg;

  typedef enum logic [2:0] {
    BEH_OFF     = 3'd0,
    BEH_ONESHOT = 3'd1,
    BEH_LATCH   = 3'd2,
    BEH_PULSER  = 3'd3,
    BEH_EXTEND  = 3'd4,
    BEH_DIV     = 3'd5,
    BEH_DIVC    = 3'd6,
    BEH_RSVD    = 3'd7
  } beh_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_OPEN = 2'd2
  } phase_e;

endpackage

// File: rtl/gdg_qual.sv
module gdg_qual (
  input  logic [3:0] mode_i,
  input  logic       trig_i,
  input  logic       sw_trig_i,
  input  logic       veto_i,
  input  logic       stop_i,
  input  logic       sw_reset_i,
  input  logic       mreset_i,
  input  logic       mreset_en_i,
  output logic       trg_o,
  output logic       stop_o
);
  logic vetoed;

  // Veto only applies when the channel is marked susceptible (bit 3).
  assign vetoed = mode_i[3] & veto_i;
  assign trg_o  = (trig_i | sw_trig_i) & ~vetoed;
  assign stop_o = stop_i | sw_reset_i | (mreset_i & mreset_en_i);

endmodule

// File: rtl/gdg_timer.sv
module gdg_timer
  import gdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             trg_i,
  input  logic             stop_i,
  output logic             gate_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Zero in a count register stands for one cycle.
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : v;
  endfunction

  // Extension add that clamps instead of wrapping.
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  beh_e             beh;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, div_q;
  logic             pulse_q;
  logic [CNT_W-1:0] d_eff, w_eff, open_next;
  logic             is_off, is_div, div_hit, starts_wait;

  assign beh         = beh_e'(mode_i[2:0]);
  assign is_off      = (beh == BEH_OFF) || (beh == BEH_RSVD);
  assign is_div      = (beh == BEH_DIV) || (beh == BEH_DIVC);
  assign d_eff       = eff_len(delay_i);
  assign w_eff       = eff_len(width_i);
  assign div_hit     = (div_q == w_eff - 1'b1);
  assign open_next   = (beh == BEH_EXTEND && trg_i) ? sat_add(cnt_q, w_eff) : cnt_q;
  assign starts_wait = (beh == BEH_PULSER) ||
                       (trg_i && (beh == BEH_ONESHOT || beh == BEH_EXTEND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      div_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (is_off || stop_i) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        div_q   <= '0;
      end else begin
        if (is_div) begin
          if (trg_i) begin
            div_q   <= div_hit ? '0 : div_q + 1'b1;
            pulse_q <= div_hit ^ (beh == BEH_DIVC);
          end
        end else begin
          div_q <= '0;
        end
        unique case (phase_q)
          PH_IDLE: begin
            if (starts_wait) begin
              phase_q <= PH_WAIT;
              cnt_q   <= d_eff - 1'b1;
            end else if (trg_i && beh == BEH_LATCH) begin
              phase_q <= PH_OPEN;
            end
          end
          PH_WAIT: begin
            if (cnt_q == '0) begin
              phase_q <= PH_OPEN;
              cnt_q   <= w_eff - 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_OPEN: begin
            if (beh != BEH_LATCH) begin
              if (open_next == '0) begin
                if (beh == BEH_PULSER) begin
                  phase_q <= PH_WAIT;
                  cnt_q   <= d_eff - 1'b1;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end else begin
                cnt_q <= open_next - 1'b1;
              end
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign gate_o = (phase_q == PH_OPEN) | pulse_q;
  assign busy_o = (phase_q != PH_IDLE);

  // R7: any merged stop leaves the channel idle with the gate low.
  assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (phase_q == PH_IDLE && !gate_o));

  // R4: a running one-shot gate just counts down, whatever triggers come.
  assert_oneshot_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beh == BEH_ONESHOT && phase_q == PH_OPEN && cnt_q != '0 && !stop_i)
    |=> (phase_q == PH_OPEN && cnt_q == $past(cnt_q) - 1'b1));

  // R5: a retrigger during the gate adds one full length.
  assert_extend_adds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beh == BEH_EXTEND && phase_q == PH_OPEN && trg_i && !stop_i &&
     !cnt_q[CNT_W-1] && !w_eff[CNT_W-1])
    |=> (phase_q == PH_OPEN && cnt_q == $past(cnt_q) + $past(w_eff) - 1'b1));

  // R6: an open latch stays open until a stop.
  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beh == BEH_LATCH && phase_q == PH_OPEN && !stop_i) |=> gate_o);

endmodule

// File: rtl/gdg_tail.sv
module gdg_tail (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic tail_o
);
  logic gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_d <= 1'b0;
    else        gate_d <= gate_i;
  end

  assign tail_o = gate_d & ~gate_i;

  // R13: the trailing marker never lasts two cycles.
  assert_tail_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tail_o |=> !tail_o);

endmodule

// File: rtl/multimode_gate_gen.sv
module multimode_gate_gen #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             trig_i,
  input  logic             stop_i,
  input  logic             veto_i,
  input  logic             mreset_i,
  input  logic             mreset_en_i,
  input  logic             sw_reset_i,
  input  logic             sw_trig_i,
  output logic             gate_o,
  output logic             tail_o
);
  logic trg_w, stop_w, busy_w;

  gdg_qual u_qual (
    .mode_i      (mode_i),
    .trig_i      (trig_i),
    .sw_trig_i   (sw_trig_i),
    .veto_i      (veto_i),
    .stop_i      (stop_i),
    .sw_reset_i  (sw_reset_i),
    .mreset_i    (mreset_i),
    .mreset_en_i (mreset_en_i),
    .trg_o       (trg_w),
    .stop_o      (stop_w)
  );

  gdg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .delay_i (delay_i),
    .width_i (width_i),
    .trg_i   (trg_w),
    .stop_i  (stop_w),
    .gate_o  (gate_o),
    .busy_o  (busy_w)
  );

  gdg_tail u_tail (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_o),
    .tail_o (tail_o)
  );

  // R11: an idle, veto-susceptible channel under veto stays idle.
  assert_veto_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && mode_i[3] && veto_i && mode_i[2:0] != 3'd3) |=> !busy_w);

  // R2: off codes drive the gate low on the next cycle.
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:0] == 3'd0 || mode_i[2:0] == 3'd7) |=> !gate_o);

endmodule

// File: tb/tb_multimode_gate_gen.sv
module tb_multimode_gate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [31:0] dly = 32'd0, wid = 32'd0;
  logic        trig = 0, stop = 0, veto = 0, mres = 0, mres_en = 0, swr = 0, swt = 0;
  logic        gate_o, tail_o;
  int          total = 0, bad = 0;
  int          o_rise, o_high, o_rises, o_tail_pos, o_tails;
  bit          done = 0;

  always #2 clk = ~clk;

  multimode_gate_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .delay_i(dly), .width_i(wid),
    .trig_i(trig), .stop_i(stop), .veto_i(veto), .mreset_i(mres),
    .mreset_en_i(mres_en), .sw_reset_i(swr), .sw_trig_i(swt),
    .gate_o(gate_o), .tail_o(tail_o)
  );

  // Table: mode, delay, width, expected rise cycle (-1 none), expected high cycles.
  localparam int NV = 7;
  localparam int VM[NV] = '{1, 1, 1, 4, 0, 7, 9};
  localparam int VD[NV] = '{3, 0, 1, 2, 2, 2, 5};
  localparam int VW[NV] = '{4, 5, 0, 3, 3, 3, 2};
  localparam int VR[NV] = '{3, 1, 1, 2, -1, -1, 5};
  localparam int VH[NV] = '{4, 5, 1, 3, 0, 0, 2};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    trig = 0; swt = 0; stop = 0; swr = 0; mres = 0;
  endtask

  task automatic idle_out();
    mode = 4'd0; veto = 0; mres_en = 0;
    step(); step(); step();
  endtask

  task automatic observe(input int m, input int d, input int w, input bit sw1,
                         input int t2, input bit sw2);
    bit prev;
    mode = 4'(m); dly = 32'(d); wid = 32'(w);
    step();
    if (sw1) swt = 1; else trig = 1;
    step();
    o_rise = -1; o_high = 0; o_rises = 0; o_tail_pos = -1; o_tails = 0;
    prev = gate_o;
    for (int n = 1; n <= 60; n++) begin
      if (n == t2) begin
        if (sw2) swt = 1; else trig = 1;
      end
      step();
      if (gate_o && !prev) begin
        o_rises++;
        if (o_rise < 0) o_rise = n;
      end
      if (gate_o) o_high++;
      if (tail_o) begin
        o_tails++;
        if (o_tail_pos < 0) o_tail_pos = n;
      end
      prev = gate_o;
    end
    idle_out();
  endtask

  task automatic prescale(input int m, input bit [8:0] pattern);
    int highs;
    highs = 0;
    mode = 4'(m); dly = 32'd0; wid = 32'd3;
    step();
    for (int i = 0; i < 9; i++) begin
      trig = 1;
      step();
      if (gate_o) highs++;
      chk(gate_o == pattern[i], (m == 5) ? "R9 answer" : "R10 answer", gate_o, pattern[i]);
      step(); if (gate_o) highs++;
      step(); if (gate_o) highs++;
    end
    chk(highs == $countones(pattern), (m == 5) ? "R9 one-cycle" : "R10 one-cycle",
        highs, $countones(pattern));
    idle_out();
  endtask

  task automatic latch_open();
    mode = 4'd2; dly = 32'd5;
    step();
    trig = 1;
    step();
    chk(gate_o == 1'b1, "R6 open", gate_o, 1);
    for (int i = 0; i < 20; i++) step();
    chk(gate_o == 1'b1, "R6 hold", gate_o, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r1, r2, run;
    bit prev;
    #1;
    chk(gate_o == 0 && tail_o == 0, "R1 in reset", gate_o, 0);
    step(); step();
    rst_n = 1;
    step();
    chk(gate_o == 0 && tail_o == 0, "R1 after reset", {gate_o, tail_o}, 0);

    // R2 R3 R5 R11: table walk
    for (int v = 0; v < NV; v++) begin
      observe(VM[v], VD[v], VW[v], 0, 0, 0);
      chk(o_rise == VR[v], $sformatf("R3/R2 rise row %0d", v), o_rise, VR[v]);
      chk(o_high == VH[v], $sformatf("R3/R2 high row %0d", v), o_high, VH[v]);
      if (VR[v] >= 0)
        chk(o_tails == 1 && o_tail_pos == VR[v] + VH[v], $sformatf("R13 tail row %0d", v),
            o_tail_pos, VR[v] + VH[v]);
    end

    // R4: one-shot ignores a trigger inside its gate
    observe(1, 2, 6, 0, 4, 0);
    chk(o_high == 6 && o_rises == 1, "R4 high", o_high, 6);
    // R4: and one inside its delay
    observe(1, 4, 2, 0, 2, 0);
    chk(o_rise == 4 && o_high == 2, "R4 delay", o_high, 2);

    // R5: extension by a full length
    observe(4, 1, 4, 0, 2, 0);
    chk(o_high == 8 && o_rises == 1, "R5 extend", o_high, 8);
    chk(o_tail_pos == 9, "R5 tail", o_tail_pos, 9);

    // R12: software strobes
    observe(1, 2, 3, 1, 0, 0);
    chk(o_rise == 2 && o_high == 3, "R12 sw trigger", o_high, 3);
    observe(4, 1, 4, 0, 3, 1);
    chk(o_high == 8, "R12 sw retrigger", o_high, 8);

    // R11: veto
    veto = 1; observe(9, 1, 2, 0, 0, 0);
    chk(o_rises == 0, "R11 vetoed", o_rises, 0);
    veto = 1; observe(1, 1, 2, 0, 0, 0);
    chk(o_rise == 1 && o_high == 2, "R11 not susceptible", o_high, 2);
    veto = 1; observe(9, 1, 2, 1, 0, 0);
    chk(o_rises == 0, "R11 vetoed sw", o_rises, 0);

    // R6 R7 R13: latch and stop sources
    latch_open();
    mres = 1; mres_en = 0; step();
    chk(gate_o == 1, "R7 masked master reset", gate_o, 1);
    stop = 1; step();
    chk(gate_o == 0 && tail_o == 1, "R7 stop_i", {gate_o, tail_o}, 1);
    step();
    chk(tail_o == 0, "R13 single cycle", tail_o, 0);
    idle_out();
    latch_open();
    swr = 1; step();
    chk(gate_o == 0 && tail_o == 1, "R7 sw_reset", {gate_o, tail_o}, 1);
    idle_out();
    latch_open();
    mres = 1; mres_en = 1; step();
    chk(gate_o == 0, "R7 master reset", gate_o, 0);
    idle_out();
    // R7: stop during a one-shot delay cancels it
    mode = 4'd1; dly = 32'd6; wid = 32'd3; step();
    trig = 1; step();
    stop = 1; step();
    run = 0;
    for (int i = 0; i < 20; i++) begin step(); if (gate_o) run++; end
    chk(run == 0, "R7 abort", run, 0);
    idle_out();

    // R8: pulser
    mode = 4'd3; dly = 32'd3; wid = 32'd2;
    r1 = -1; r2 = -1; run = 0; prev = 0;
    for (int n = 0; n < 40; n++) begin
      step();
      if (gate_o && !prev) begin
        if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
      end
      if (gate_o && r1 >= 0 && r2 < 0) run++;
      prev = gate_o;
    end
    chk(r1 >= 0 && r2 - r1 == 5, "R8 period", r2 - r1, 5);
    chk(run == 2, "R8 high", run, 2);
    idle_out();

    // R9 R10: prescalers, N=3; bit i is trigger i+1
    prescale(5, 9'b100100100);
    prescale(6, 9'b011011011);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule